// File: doc/BRIEF.md
# Windowed Integer Register File with Single-Error Correction

This block holds the integer registers of a windowed load/store processor core: eight globals and eight overlapping windows of sixteen registers each, 136 physical rows in all, kept in flip-flops. Two read ports and one write port share one current-window pointer. On every access a 5-bit logical register number is turned into a physical row. Registers 1 to 7 are shared by all windows. Registers 8 to 31 depend on the window. The outputs of window w are the same storage as the inputs of window w-1, wrapping modulo 8.

Each row holds a 39-bit codeword: 32 data bits and 7 check bits of a Hamming single-error-correct, double-error-detect code, generated once on write. Each read port decodes its own word. It corrects a single flipped bit on its data output and flags it as correctable, or flags a double flip as uncorrectable. A write-side corruption mask lets a fault be planted in the stored codeword, so the correction path can be exercised.

Top module: `wrf_edac`

## Requirements
- R1: After reset every register on both ports reads 0, with both error flags low.
- R2: A read address presented at a clock edge yields its data after that edge, so data arrives one cycle after the address. The two ports read different rows in the same cycle.
- R3: Register 0 reads 0 with both flags low in every window. Writes to register 0 are discarded.
- R4: Registers 1 to 7 name the same storage regardless of the window pointer.
- R5: With pointer w, registers 8+k (k = 0..7) name the same storage as registers 24+k under pointer (w-1) mod 8, including the wrap from 0 to 7. Registers 16 to 31 of one window are private to it.
- R6: A read of the row being written in the same cycle returns the value stored before that write. The next read returns the new value.
- R7: The corruption mask is XORed into the whole 39-bit stored codeword on write. If exactly one mask bit is set, in any of the 39 positions, later reads return the original data with the correctable flag high and the uncorrectable flag low.
- R8: If exactly two mask bits are set, later reads raise the uncorrectable flag with the correctable flag low.
- R9: Each port's flags describe only the word that port read. A clean word on one port shows no flags while the other port reports an error.
- R10: On each port the correctable and uncorrectable flags are never high together.
- R11: With the write enable low, no register changes, whatever is on the write address and data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cwp_i | input | 3 | Current window pointer |
| ra_addr_i | input | 5 | Read port A register number |
| rb_addr_i | input | 5 | Read port B register number |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | 32 | Write data |
| inj_mask_i | input | 39 | XOR mask applied to the stored codeword |
| ra_data_o | output | 32 | Port A data, corrected |
| ra_ce_o | output | 1 | Port A single-bit error corrected |
| ra_ue_o | output | 1 | Port A uncorrectable error |
| rb_data_o | output | 32 | Port B data, corrected |
| rb_ce_o | output | 1 | Port B single-bit error corrected |
| rb_ue_o | output | 1 | Port B uncorrectable error |

## Verification
Two things can happen in one cycle: a write can land on a row while a read port samples that same row, and both ports can decode corrupted words at once. The bench provokes the first directly, by writing and reading register 10 in one cycle. The port must show the old value, and the following cycle the new one. Random traffic over a small address range provokes both cases many more times, with one-bit and two-bit masks mixed in. A reference model tracks, for each physical row, its last data and the number of bits flipped. It predicts each port's data and flags from the state before the write in that cycle.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  parameter int unsigned DW       = 32;
  parameter int unsigned CBW      = 7;
  parameter int unsigned NWIN     = 8;
  parameter int unsigned NGLOB    = 8;
  parameter int unsigned NREG_WIN = 16;
  parameter int unsigned AW       = 5;
  parameter int unsigned NRP      = 2;

  localparam int unsigned CWW   = DW + CBW;          // stored codeword width
  localparam int unsigned HB    = CBW - 1;           // Hamming check bits
  localparam int unsigned NPOS  = DW + HB;           // Hamming positions 1..NPOS
  localparam int unsigned WPW   = $clog2(NWIN);
  localparam int unsigned NROWS = NGLOB + NWIN * NREG_WIN;
  localparam int unsigned RW    = $clog2(NROWS);
  localparam int unsigned GRP   = NREG_WIN / 2;      // locals or ins per window

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction
endpackage

// File: rtl/wrf_win_map.sv
module wrf_win_map
  import wrf_pkg::*;
(
  input  logic [WPW-1:0] cwp_i,
  input  logic [AW-1:0]  addr_i,
  output logic [RW-1:0]  row_o,
  output logic           zero_o
);
  logic [WPW-1:0] prev_w;
  int             row;

  assign prev_w = cwp_i - WPW'(1);  // wraps modulo NWIN
  assign zero_o = (addr_i == '0);

  always_comb begin
    row = 0;
    case (addr_i[AW-1:AW-2])
      2'b00: row = int'(addr_i);                                        // globals
      2'b01: row = NGLOB + int'(prev_w) * NREG_WIN + GRP + int'(addr_i[2:0]); // outs
      2'b10: row = NGLOB + int'(cwp_i)  * NREG_WIN + int'(addr_i[2:0]);       // locals
      default: row = NGLOB + int'(cwp_i) * NREG_WIN + GRP + int'(addr_i[2:0]); // ins
    endcase
    row_o = RW'(row);
  end
endmodule

// File: rtl/wrf_secded_enc.sv
module wrf_secded_enc
  import wrf_pkg::*;
(
  input  logic [DW-1:0]  data_i,
  output logic [CWW-1:0] cw_o
);
  logic [CWW-1:0] cw;

  always_comb begin
    int  di;
    logic par;
    cw = '0;
    di = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = data_i[di];
        di++;
      end
    end
    for (int j = 0; j < HB; j++) begin
      par = 1'b0;
      for (int p = 1; p <= NPOS; p++)
        if (!is_pow2(p) && ((p >> j) & 1) == 1) par ^= cw[p];
      cw[1 << j] = par;
    end
    cw[0] = ^cw[NPOS:1];  // overall parity
  end

  assign cw_o = cw;
endmodule

// File: rtl/wrf_secded_dec.sv
module wrf_secded_dec
  import wrf_pkg::*;
(
  input  logic [CWW-1:0] cw_i,
  output logic [DW-1:0]  data_o,
  output logic           ce_o,
  output logic           ue_o
);
  logic [HB-1:0] syn;
  logic          par;
  logic          in_rng;
  logic          fix;

  always_comb begin
    syn = '0;
    for (int p = 1; p <= NPOS; p++)
      if (cw_i[p]) syn ^= HB'(p);
  end

  assign par    = ^cw_i;
  assign in_rng = (syn != '0) && (int'(syn) <= NPOS);
  assign fix    = par && in_rng;
  assign ce_o   = par && ((syn == '0) || in_rng);
  assign ue_o   = (!par && (syn != '0)) || (par && (syn != '0) && !in_rng);

  always_comb begin
    int di;
    di = 0;
    data_o = '0;
    for (int p = 1; p <= NPOS; p++) begin
      if (!is_pow2(p)) begin
        data_o[di] = cw_i[p] ^ (fix && (syn == HB'(p)));
        di++;
      end
    end
  end
endmodule

// File: rtl/wrf_edac.sv
module wrf_edac
  import wrf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WPW-1:0]   cwp_i,
  input  logic [AW-1:0]    ra_addr_i,
  input  logic [AW-1:0]    rb_addr_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [CWW-1:0]   inj_mask_i,
  output logic [DW-1:0]    ra_data_o,
  output logic             ra_ce_o,
  output logic             ra_ue_o,
  output logic [DW-1:0]    rb_data_o,
  output logic             rb_ce_o,
  output logic             rb_ue_o
);
  logic [CWW-1:0] mem_q [NROWS];

  logic [RW-1:0]  wr_row;
  logic           wr_zero;
  logic [CWW-1:0] wr_cw;

  wrf_win_map u_wmap (
    .cwp_i  (cwp_i),
    .addr_i (wr_addr_i),
    .row_o  (wr_row),
    .zero_o (wr_zero)
  );

  wrf_secded_enc u_enc (
    .data_i (wr_data_i),
    .cw_o   (wr_cw)
  );

  // single write bank; row 0 is never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NROWS; r++) mem_q[r] <= '0;
    end else if (we_i && !wr_zero) begin
      mem_q[wr_row] <= wr_cw ^ inj_mask_i;
    end
  end

  logic [AW-1:0] rd_addr [NRP];
  logic [DW-1:0] rd_data [NRP];
  logic          rd_ce   [NRP];
  logic          rd_ue   [NRP];

  assign rd_addr[0] = ra_addr_i;
  assign rd_addr[1] = rb_addr_i;

  for (genvar g = 0; g < NRP; g++) begin : g_rport
    logic [RW-1:0]  row;
    logic           zero;
    logic [CWW-1:0] cw_q;
    logic           zero_q;
    logic [DW-1:0]  dec_data;
    logic           dec_ce;
    logic           dec_ue;

    wrf_win_map u_map (
      .cwp_i  (cwp_i),
      .addr_i (rd_addr[g]),
      .row_o  (row),
      .zero_o (zero)
    );

    // sampled before this edge's write lands: old-data semantics
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cw_q   <= '0;
        zero_q <= 1'b1;
      end else begin
        cw_q   <= mem_q[row];
        zero_q <= zero;
      end
    end

    wrf_secded_dec u_dec (
      .cw_i   (cw_q),
      .data_o (dec_data),
      .ce_o   (dec_ce),
      .ue_o   (dec_ue)
    );

    assign rd_data[g] = zero_q ? '0 : dec_data;
    assign rd_ce[g]   = !zero_q && dec_ce;
    assign rd_ue[g]   = !zero_q && dec_ue;
  end

  assign ra_data_o = rd_data[0];
  assign ra_ce_o   = rd_ce[0];
  assign ra_ue_o   = rd_ue[0];
  assign rb_data_o = rd_data[1];
  assign rb_ce_o   = rd_ce[1];
  assign rb_ue_o   = rd_ue[1];
endmodule

// File: rtl/wrf_edac_chk.sv
module wrf_edac_chk
  import wrf_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] ra_addr_i,
  input logic [AW-1:0] rb_addr_i,
  input logic [DW-1:0] ra_data_o,
  input logic          ra_ce_o,
  input logic          ra_ue_o,
  input logic [DW-1:0] rb_data_o,
  input logic          rb_ce_o,
  input logic          rb_ue_o
);
  // R10
  a_r10_flags_excl_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ra_ce_o && ra_ue_o));
  a_r10_flags_excl_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rb_ce_o && rb_ue_o));

  // R3
  a_r3_zero_reg_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ra_addr_i) == '0) |-> (ra_data_o == '0 && !ra_ce_o && !ra_ue_o));
  a_r3_zero_reg_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rb_addr_i) == '0) |-> (rb_data_o == '0 && !rb_ce_o && !rb_ue_o));

  // R9: both ports on one register see the same word and the same flags
  a_r9_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ra_addr_i) == $past(rb_addr_i)) |->
      (ra_data_o == rb_data_o && ra_ce_o == rb_ce_o && ra_ue_o == rb_ue_o));
endmodule

bind wrf_edac wrf_edac_chk chk_i (.*);

// File: tb/wrf_edac_tb_top.sv
module wrf_edac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cwp = '0;
  logic [4:0]  ra = '0, rb = '0, wa = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [38:0] mask = '0;
  logic [31:0] ra_d, rb_d;
  logic        ra_ce, ra_ue, rb_ce, rb_ue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_data  [136];
  int          m_flips [136];

  always #5 clk = ~clk;

  wrf_edac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cwp_i(cwp),
    .ra_addr_i(ra), .rb_addr_i(rb),
    .we_i(we), .wr_addr_i(wa), .wr_data_i(wd), .inj_mask_i(mask),
    .ra_data_o(ra_d), .ra_ce_o(ra_ce), .ra_ue_o(ra_ue),
    .rb_data_o(rb_d), .rb_ce_o(rb_ce), .rb_ue_o(rb_ue)
  );

  function automatic int phys(input int w, input int a);
    if (a < 8)  return a;
    if (a < 16) return 8 + ((w + 7) % 8) * 16 + 8 + (a - 8);
    if (a < 24) return 8 + w * 16 + (a - 16);
    return 8 + w * 16 + 8 + (a - 24);
  endfunction

  task automatic chk_port(input string tag, input string pn, input int a,
                          input int w, input logic [31:0] gd,
                          input logic gce, input logic gue,
                          input logic [31:0] ed, input int fl);
    string t;
    logic ece, eue;
    t = tag;
    if (a == 0) begin ed = '0; fl = 0; end
    ece = (fl == 1);
    eue = (fl == 2);
    if (t == "") t = (a == 0) ? "R3" : (fl == 1) ? "R7" : (fl == 2) ? "R8" : "R2";
    checks++;
    if (gce !== ece || gue !== eue || (!eue && gd !== ed)) begin
      errors++;
      $display("FAIL %s port %s r%0d w%0d: got d=%h ce=%b ue=%b exp d=%h ce=%b ue=%b",
               t, pn, a, w, gd, gce, gue, ed, ece, eue);
    end
    checks++;
    if (gce && gue) begin
      errors++;
      $display("FAIL R10 port %s: got ce=%b ue=%b exp not both", pn, gce, gue);
    end
  endtask

  task automatic cyc(input int w, input int a, input int b, input bit e,
                     input int x, input logic [31:0] d, input logic [38:0] mk,
                     input string tag);
    logic [31:0] ead, ebd;
    int          efa, efb, ra_row, rb_row;
    cwp = 3'(w); ra = 5'(a); rb = 5'(b); we = e; wa = 5'(x); wd = d; mask = mk;
    ra_row = phys(w, a); rb_row = phys(w, b);
    ead = m_data[ra_row]; efa = m_flips[ra_row];
    ebd = m_data[rb_row]; efb = m_flips[rb_row];
    @(posedge clk);
    #2;
    if (e && x != 0) begin
      m_data[phys(w, x)]  = d;
      m_flips[phys(w, x)] = $countones(mk);
    end
    chk_port(tag, "A", a, w, ra_d, ra_ce, ra_ue, ead, efa);
    chk_port(tag, "B", b, w, rb_d, rb_ce, rb_ue, ebd, efb);
  endtask

  function automatic logic [38:0] rnd_mask();
    int r, i, j;
    r = int'($urandom % 10);
    if (r < 6) return '0;
    i = int'($urandom % 39);
    if (r < 8) return 39'(1) << i;
    j = (i + 1 + int'($urandom % 38)) % 39;
    return (39'(1) << i) | (39'(1) << j);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int r = 0; r < 136; r++) begin m_data[r] = '0; m_flips[r] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset contents
    cyc(0, 1, 9, 0, 0, 0, '0, "R1");
    cyc(3, 17, 31, 0, 0, 0, '0, "R1");
    cyc(7, 8, 24, 0, 0, 0, '0, "R1");
    cyc(5, 15, 23, 0, 0, 0, '0, "R1");

    // R3: writes to register 0 are dropped
    cyc(2, 0, 0, 1, 0, 32'hdeadbeef, '0, "R3");
    cyc(6, 0, 0, 1, 0, 32'h12345678, 39'h1, "R3");
    cyc(2, 0, 0, 0, 0, 0, '0, "R3");

    // R4: globals shared across windows
    cyc(0, 0, 0, 1, 5, 32'ha5a5a5a5, '0, "R4");
    cyc(5, 5, 5, 0, 0, 0, '0, "R4");
    cyc(7, 5, 1, 0, 0, 0, '0, "R4");

    // R5: outs alias ins of previous window, incl wrap; locals private
    cyc(3, 0, 0, 1, 24, 32'h0bad0001, '0, "R5");
    cyc(4, 8, 24, 0, 0, 0, '0, "R5");
    cyc(7, 0, 0, 1, 31, 32'h0bad0002, '0, "R5");
    cyc(0, 15, 31, 0, 0, 0, '0, "R5");
    cyc(2, 0, 0, 1, 16, 32'h0bad0003, '0, "R5");
    cyc(6, 16, 16, 0, 0, 0, '0, "R5");
    cyc(2, 16, 8, 0, 0, 0, '0, "R5");

    // R6: read during write returns old value
    cyc(1, 0, 0, 1, 10, 32'h11110000, '0, "R6");
    cyc(1, 10, 0, 1, 10, 32'h22220000, '0, "R6");
    cyc(1, 10, 10, 0, 0, 0, '0, "R6");

    // R7 / R8 / R9: corrupted words, per-port flags
    cyc(4, 0, 0, 1, 20, 32'hcafef00d, 39'h1 << 38, "R7");
    cyc(4, 0, 0, 1, 21, 32'h0f0f0f0f, (39'h1 << 3) | (39'h1 << 17), "R8");
    cyc(4, 0, 0, 1, 22, 32'h600dd00d, '0, "R9");
    cyc(4, 20, 21, 0, 0, 0, '0, "R9");
    cyc(4, 22, 20, 0, 0, 0, '0, "R9");
    cyc(4, 0, 0, 1, 20, 32'h00000001, 39'h1, "R7");
    cyc(4, 20, 22, 0, 0, 0, '0, "R7");

    // R11: disabled write changes nothing
    cyc(0, 0, 0, 1, 3, 32'h33333333, '0, "R11");
    cyc(0, 0, 0, 0, 3, 32'hffffffff, '0, "R11");
    cyc(5, 3, 3, 0, 0, 0, '0, "R11");

    // random traffic over all windows
    for (int i = 0; i < 3000; i++) begin
      cyc(int'($urandom % 8), int'($urandom % 32), int'($urandom % 32),
          bit'($urandom % 2), int'($urandom % 32), $urandom, rnd_mask(), "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule